// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

The block is an 18-bit first-in first-out buffer whose write port and read port run on separate clocks. The two clocks may be unrelated or may be the same clock. Depth is a power-of-two parameter. Each side keeps its own binary pointer and sends a Gray-coded copy of it to the other side through a two-stage synchroniser. The write side decides full, half-full and almost-full. The read side decides empty and almost-empty.

The write port is a valid/ready stream. A word is taken on a rising edge of `wclk` when `wr_valid` and `wr_ready` are both high. `wr_ready` drops while the buffer holds `DEPTH` words, and that is the only back-pressure the producer sees. On the read side, the consumer raises `rd_ready`. A word is taken on a rising edge of `rclk` when `rd_ready` is high and `empty` is low. The word is then loaded into an output register, and `rd_valid` is high for exactly the one `rclk` cycle that follows. The delivered word cannot be stalled. `oe` decides whether the registered word drives `rd_data`.

Two offset registers set the almost-empty and almost-full thresholds. Each can be reloaded at run time from its own clock domain. `flag_async` selects how the two almost flags are produced. With `flag_async` low, each almost flag is a register clocked only by its own domain. With `flag_async` high, each almost flag follows the raw pointers of both domains with no synchroniser. A retransmit pulse rewinds the read pointer so that the stored words are read again from the first one.

Top module: `dcfifo_pflags`

## Requirements
- R1: A word is stored on a `wclk` rising edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the write side sees `DEPTH` words stored. A word offered while `wr_ready` is low is never stored.
- R2: A word is removed on an `rclk` rising edge when `rd_ready` is high, `empty` is low and `retransmit` is low. That word sits in the output register with `rd_valid` high for the following `rclk` cycle. A read request while `empty` is high leaves `rd_valid` low.
- R3: Words leave in the order they were accepted, with no loss and no duplication, while the two clocks run at unrelated rates.
- R4: After reset both pointers are zero. `empty` is 1, `full` is 0, `wr_ready` is 1 and `rd_valid` is 0. Once the pointers have crossed between domains, `empty` is 1 exactly when no word is stored, and `full` is 1 exactly when `DEPTH` words are stored.
- R5: `half_full` is 1 when more than `DEPTH/2` words are stored, and 0 at `DEPTH/2` words or fewer.
- R6: `almost_empty` is 1 when the stored count is at most the empty offset n. After reset, n is `DEPTH/8`.
- R7: `almost_full` is 1 when the stored count is at least `DEPTH - m`, where m is the full offset. After reset, m is `DEPTH/8`.
- R8: With `flag_async` = 0, `almost_full` changes only on a `wclk` edge and `almost_empty` only on an `rclk` edge, so a read is seen by `almost_full` only after the synchroniser delay. With `flag_async` = 1, both almost flags follow the raw pointers at once.
- R9: Pulsing `ae_load` on `rclk` loads `ae_value` into n. Pulsing `af_load` on `wclk` loads `af_value` into m. Each offset accepts values 0 to `DEPTH`. A new offset is used from the next edge of its domain and stays until the next load or reset.
- R10: A `retransmit` pulse on `rclk` sets the read pointer back to zero, so the next reads return the words from the first word written since reset. In the same cycle it overrides a read request: no word is removed and `rd_valid` stays low. This holds while no more than `DEPTH` words have been written since reset.
- R11: With `oe` = 0, `rd_data` is all zeros and `rd_drive` is 0. With `oe` = 1, `rd_drive` is 1 and `rd_data` shows the output register. `oe` has no effect on the stored words or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word (not full) |
| wr_data | input | 18 | Write data |
| rd_ready | input | 1 | Consumer requests a word |
| rd_valid | output | 1 | Output register holds a newly read word this cycle |
| rd_data | output | 18 | Read data, forced to zero when `oe` is low |
| oe | input | 1 | Output enable for `rd_data` |
| rd_drive | output | 1 | Read data is being driven (models the tri-state enable) |
| empty | output | 1 | No word stored (read domain) |
| full | output | 1 | `DEPTH` words stored (write domain) |
| half_full | output | 1 | More than `DEPTH/2` words stored (write domain) |
| almost_empty | output | 1 | Stored count at most the empty offset |
| almost_full | output | 1 | Stored count at least `DEPTH` minus the full offset |
| flag_async | input | 1 | 0: almost flags registered per domain; 1: raw pointer compare |
| ae_load | input | 1 | Load `ae_value` into the empty offset (rclk) |
| ae_value | input | log2(DEPTH)+1 | New empty offset |
| af_load | input | 1 | Load `af_value` into the full offset (wclk) |
| af_value | input | log2(DEPTH)+1 | New full offset |
| retransmit | input | 1 | Rewind the read pointer to zero (rclk) |

## Verification
A retransmit pulse and a read request can land on the same `rclk` edge. The bench raises both together on a partly read buffer. It then requires `rd_valid` to stay low in the next cycle, and it requires the following reads to restart from the first word written. The almost-full flag can be recomputed on a `wclk` edge while a read changes the count on the other clock. The bench performs a single read next to the almost-full threshold and samples `almost_full` one nanosecond later, in both flag modes. The sync mode must still show the old level, and the raw mode must already show the new one.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W      = 18;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] rbin_raw,
  input  logic          flag_async,
  input  logic          af_load,
  input  logic [PW-1:0] af_value,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          push,
  output logic          full,
  output logic          half_full,
  output logic          almost_full
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
  localparam logic [PW-1:0] OFF_RST  = PW'(DEPTH / 8);

  logic [PW-1:0] rbin_s, wcount, wbin_nx, af_off, af_thr;
  logic          af_reg, af_raw;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wcount    = wbin - rbin_s;
  assign full      = (wcount == FULL_CNT);
  assign half_full = (wcount > HALF_CNT);
  assign wr_ready  = !full;
  assign push      = wr_valid && !full;
  assign wbin_nx   = wbin + PW'(push);
  assign af_thr    = FULL_CNT - af_off;
  assign af_raw    = ((wbin - rbin_raw) >= af_thr);
  assign almost_full = flag_async ? af_raw : af_reg;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      af_off <= OFF_RST;
      af_reg <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      af_reg <= ((wbin_nx - rbin_s) >= af_thr);
      if (af_load) af_off <= af_value;
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic          retransmit,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] wbin_raw,
  input  logic          flag_async,
  input  logic          ae_load,
  input  logic [PW-1:0] ae_value,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          pop,
  output logic          empty,
  output logic          almost_empty,
  output logic          rd_valid
);
  localparam logic [PW-1:0] OFF_RST = PW'(DEPTH / 8);

  logic [PW-1:0] wbin_s, rbin_nx, ae_off;
  logic          ae_reg, ae_raw;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign empty   = (wbin_s == rbin);
  assign pop     = rd_ready && !empty && !retransmit;
  assign rbin_nx = retransmit ? '0 : rbin + PW'(pop);
  assign ae_raw  = ((wbin_raw - rbin) <= ae_off);
  assign almost_empty = flag_async ? ae_raw : ae_reg;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      ae_off   <= OFF_RST;
      ae_reg   <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      ae_reg   <= ((wbin_s - rbin_nx) <= ae_off);
      rd_valid <= pop;
      if (ae_load) ae_off <= ae_value;
    end
  end
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int DEPTH = 16,
  parameter int DW    = dcf_pkg::DATA_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          oe,
  output logic          rd_drive,
  output logic          empty,
  output logic          full,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full,
  input  logic          flag_async,
  input  logic          ae_load,
  input  logic [PW-1:0] ae_value,
  input  logic          af_load,
  input  logic [PW-1:0] af_value,
  input  logic          retransmit
);
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic          push, pop;
  logic [DW-1:0] rd_q;

  dcf_sync #(.W(PW)) u_sync_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_sync_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rgray_s(rgray_s), .rbin_raw(rbin), .flag_async(flag_async),
    .af_load(af_load), .af_value(af_value), .wbin(wbin), .wgray(wgray),
    .push(push), .full(full), .half_full(half_full), .almost_full(almost_full)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_ready(rd_ready), .retransmit(retransmit),
    .wgray_s(wgray_s), .wbin_raw(wbin), .flag_async(flag_async),
    .ae_load(ae_load), .ae_value(ae_value), .rbin(rbin), .rgray(rgray),
    .pop(pop), .empty(empty), .almost_empty(almost_empty), .rd_valid(rd_valid)
  );

  dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(push), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .rst_n(rst_n), .re(pop), .raddr(rbin[AW-1:0]), .rdata(rd_q)
  );

  assign rd_drive = oe;
  assign rd_data  = oe ? rd_q : '0;
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk #(
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full,
  input logic          empty,
  input logic          rd_ready,
  input logic          retransmit,
  input logic          rd_valid,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  // R1: while full, the write pointer does not move
  a_r1_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> (wgray == $past(wgray)));

  // R2: a read request against an empty buffer yields no word
  a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> !rd_valid);

  // R2: an accepted read produces rd_valid in the next cycle
  a_r2_read_delivers: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_ready && !empty && !retransmit) |=> rd_valid);

  // R3: the write pointer seen by the other domain changes by one bit at most
  a_r3_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  // R3: the read pointer steps by one Gray bit unless it is rewound
  a_r3_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
    !retransmit |=> ($countones(rgray ^ $past(rgray)) <= 1));

  // R10: retransmit rewinds the pointer and overrides a same-cycle read
  a_r10_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    retransmit |=> (rgray == '0) && !rd_valid);
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full(full), .empty(empty),
  .rd_ready(rd_ready), .retransmit(retransmit), .rd_valid(rd_valid),
  .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_pflags_tb_top.sv
module dcfifo_pflags_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH) + 1;
  localparam int DW    = 18;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, oe = 1'b1, flag_async = 1'b0;
  logic ae_load = 1'b0, af_load = 1'b0, retransmit = 1'b0;
  logic [PW-1:0] ae_value = '0, af_value = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, rd_drive, empty, full, half_full, almost_empty, almost_full;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q [$];
  bit mon_en = 1'b1;

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_pflags #(.DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .oe(oe), .rd_drive(rd_drive), .empty(empty), .full(full), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full), .flag_async(flag_async),
    .ae_load(ae_load), .ae_value(ae_value), .af_load(af_load), .af_value(af_value),
    .retransmit(retransmit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every delivered word is compared with the scoreboard head
  always @(negedge rclk) begin
    logic [DW-1:0] e;
    if (mon_en && rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R3 word with empty scoreboard", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R3 order", 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge wclk);
    @(posedge wclk);
    exp_q.push_back(d);
    #1 wr_valid = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) push(base + DW'(i));
  endtask

  task automatic pop_one();
    @(negedge rclk);
    rd_ready = 1'b1;
    while (empty) @(negedge rclk);
    @(posedge rclk);
    #1 rd_ready = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) pop_one();
  endtask

  task automatic settle();
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    do_reset();
    // reset state
    chk("R4 empty after reset", empty, 1);
    chk("R4 full after reset", full, 0);
    chk("R4 wr_ready after reset", wr_ready, 1);
    chk("R4 rd_valid after reset", rd_valid, 0);
    chk("R6 almost_empty at 0 words", almost_empty, 1);
    chk("R7 almost_full at 0 words", almost_full, 0);
    chk("R5 half_full at 0 words", half_full, 0);

    // read while empty is ignored
    @(negedge rclk); rd_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk);
      chk("R2 read while empty", rd_valid, 0);
    end
    rd_ready = 1'b0;

    // small transfer
    push_n(3, 18'h100);
    settle();
    chk("R4 empty with 3 words", empty, 0);
    chk("R6 almost_empty at 3 words (n=2)", almost_empty, 0);
    pop_n(3);
    settle();
    chk("R4 empty after drain", empty, 1);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    // level boundaries
    push_n(8, 18'h200);
    settle();
    chk("R5 half_full at 8 words", half_full, 0);
    push_n(1, 18'h208);
    settle();
    chk("R5 half_full at 9 words", half_full, 1);
    push_n(4, 18'h209);
    settle();
    chk("R7 almost_full at 13 words (m=2)", almost_full, 0);
    push_n(1, 18'h20D);
    settle();
    chk("R7 almost_full at 14 words", almost_full, 1);
    push_n(2, 18'h20E);
    settle();
    chk("R4 full at 16 words", full, 1);
    chk("R1 wr_ready low when full", wr_ready, 0);
    @(negedge wclk); wr_valid = 1'b1; wr_data = 18'h3FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge wclk);
      chk("R1 write while full refused", wr_ready, 0);
    end
    wr_valid = 1'b0;
    pop_n(16);
    settle();
    chk("R1 dropped word not stored (empty after 16 reads)", empty, 1);
    chk("R3 scoreboard drained after fill", exp_q.size(), 0);

    // offset reload
    @(negedge rclk); ae_value = PW'(5); ae_load = 1'b1;
    @(negedge rclk); ae_load = 1'b0;
    push_n(5, 18'h300);
    settle();
    chk("R9 almost_empty at 5 words with n=5", almost_empty, 1);
    push_n(1, 18'h305);
    settle();
    chk("R9 almost_empty at 6 words with n=5", almost_empty, 0);
    @(negedge wclk); af_value = PW'(10); af_load = 1'b1;
    @(negedge wclk); af_load = 1'b0;
    settle();
    chk("R9 almost_full at 6 words with m=10", almost_full, 1);
    @(negedge wclk); af_value = PW'(9); af_load = 1'b1;
    @(negedge wclk); af_load = 1'b0;
    settle();
    chk("R9 almost_full at 6 words with m=9", almost_full, 0);
    pop_n(6);
    @(negedge rclk); ae_value = PW'(2); ae_load = 1'b1;
    @(negedge rclk); ae_load = 1'b0;
    @(negedge wclk); af_value = PW'(2); af_load = 1'b1;
    @(negedge wclk); af_load = 1'b0;
    settle();

    // flag mode: sync lags, raw follows at once
    push_n(14, 18'h400);
    settle();
    chk("R7 almost_full at 14 before mode test", almost_full, 1);
    pop_one();
    chk("R8 sync almost_full still set right after read", almost_full, 1);
    settle();
    chk("R8 sync almost_full clears after sync delay", almost_full, 0);
    flag_async = 1'b1;
    push_n(1, 18'h40E);
    #1;
    chk("R8 raw almost_full at 14", almost_full, 1);
    pop_one();
    chk("R8 raw almost_full clears right after read", almost_full, 0);
    flag_async = 1'b0;
    pop_n(13);
    settle();
    chk("R3 scoreboard drained after mode test", exp_q.size(), 0);

    // retransmit with a same-cycle read request
    do_reset();
    push_n(5, 18'h500);
    pop_n(2);
    @(negedge rclk); retransmit = 1'b1; rd_ready = 1'b1;
    @(posedge rclk);
    #1 retransmit = 1'b0; rd_ready = 1'b0;
    @(negedge rclk);
    chk("R10 retransmit overrides read", rd_valid, 0);
    exp_q.delete();
    for (int i = 0; i < 5; i++) exp_q.push_back(18'h500 + DW'(i));
    pop_n(5);
    settle();
    chk("R10 all words replayed", exp_q.size(), 0);
    chk("R10 empty after replay", empty, 1);

    // output enable
    mon_en = 1'b0;
    w = 18'h2A5A5;
    push(w);
    exp_q.delete();
    settle();
    oe = 1'b0;
    pop_one();
    @(negedge rclk);
    chk("R2 rd_valid after accepted read", rd_valid, 1);
    chk("R11 rd_data zero with oe low", 32'(rd_data), 0);
    chk("R11 rd_drive low with oe low", rd_drive, 0);
    oe = 1'b1;
    #1;
    chk("R11 rd_data shows word with oe high", 32'(rd_data), 32'(w));
    chk("R11 rd_drive high with oe high", rd_drive, 1);
    @(posedge rclk);
    #1 mon_en = 1'b1;
    settle();
    chk("R11 oe left buffer empty", empty, 1);

    // interleaved stream on unrelated clocks
    fork
      for (int i = 0; i < 40; i++) begin
        push(18'h1000 + DW'(i * 7));
        if (i % 3 == 0) repeat (2) @(posedge wclk);
      end
      for (int i = 0; i < 40; i++) begin
        pop_one();
        if (i % 5 == 0) repeat (3) @(posedge rclk);
      end
    join
    settle();
    chk("R3 stream fully delivered", exp_q.size(), 0);
    chk("R4 empty after stream", empty, 1);

    summary();
    $finish;
  end
endmodule